// File: doc/BRIEF.md
# Iterative integer square root

This block computes the floor of the square root of an unsigned operand `WIDTH` bits wide, together with the remainder. It settles one root bit per clock cycle, starting from the most significant root position and moving down. A register holds the square of the partial root. Each step forms the square of the next candidate from that register using only shifts and additions, so the block needs no multiplier.

A client raises `start_i` with the operand while the unit is idle. `done_o` then pulses for one cycle, and the root and remainder can be read from that cycle on. Before the first step, a leading-pair detector finds the highest non-zero bit pair of the operand. Zero pairs above it are skipped, so small operands finish in fewer cycles, and a zero operand finishes at once.

Top module: `isqrt_seq`

## Requirements
- R1: When `done_o` is high, `root_o` satisfies root*root <= operand < (root+1)*(root+1), where operand is the value sampled with the accepted start.
- R2: When `done_o` is high, `rem_o` (`WIDTH/2+1` bits) equals the operand minus root*root.
- R3: For a non-zero operand whose leftmost set bit is at position p, `done_o` goes high on the (floor(p/2)+1)-th rising edge after the edge that accepts start.
- R4: A zero operand is done on the accepting edge itself, with `root_o` = 0 and `rem_o` = 0.
- R5: `done_o` is high for exactly one cycle per operation, and `busy_o` is high from the accepting edge through the cycle in which `done_o` is high.
- R6: `start_i` is sampled only while `busy_o` is low. A start with another operand while busy has no effect on the result of the operation in progress.
- R7: After `done_o`, `root_o` and `rem_o` stay unchanged until the next accepted start.
- R8: While `rst_ni` is low, `busy_o`, `done_o`, `root_o` and `rem_o` are all 0.
- R9: The all-ones operand gives root 2^(WIDTH/2)-1 and remainder 2^(WIDTH/2+1)-2, and the candidate square never overflows its `WIDTH+1`-bit adder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin; taken only while idle |
| operand_i | input | WIDTH | Unsigned radicand, sampled with start |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| root_o | output | WIDTH/2 | Floor of the square root |
| rem_o | output | WIDTH/2+1 | Operand minus root squared |

## Verification
Powers of two cover every start position of the leading-pair detector, and they show whether the iteration count follows the top set bit. Perfect squares and the values just below them give a remainder of zero or of 2*root, which exposes an off-by-one in the keep/discard comparison. The all-ones and zero operands mark the two ends of the range: the full-length run with the largest candidate sums, and the immediate exit. Random operands, and a start issued during a long run, check the bracket property in general and that the latched operand is protected.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } isqrt_state_e;
endpackage

// File: rtl/isqrt_lead.sv
// Finds the highest non-zero bit pair of the operand.
module isqrt_lead #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned HALF = WIDTH / 2,
  localparam int unsigned KW   = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic [WIDTH-1:0] op_i,
  output logic             zero_o,
  output logic [KW-1:0]    top_pair_o
);
  logic [HALF-1:0] pair_nz;

  for (genvar g = 0; g < HALF; g++) begin : g_pair
    assign pair_nz[g] = |op_i[2*g+1 -: 2];
  end

  always_comb begin
    top_pair_o = '0;
    for (int i = 0; i < HALF; i++) begin
      if (pair_nz[i]) top_pair_o = KW'(i);
    end
  end

  assign zero_o = ~|pair_nz;
endmodule

// File: rtl/isqrt_step.sv
// One trial step: candidate square from stored square by shift-and-add.
module isqrt_step #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned HALF = WIDTH / 2,
  localparam int unsigned KW   = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic [WIDTH-1:0] op_i,
  input  logic [WIDTH-1:0] sq_i,
  input  logic [HALF-1:0]  root_i,
  input  logic [KW-1:0]    bit_i,
  output logic             keep_o,
  output logic             ovf_o,
  output logic [WIDTH-1:0] sq_next_o,
  output logic [HALF-1:0]  root_next_o
);
  logic [WIDTH:0] cross_term;
  logic [WIDTH:0] bit_term;
  logic [WIDTH:0] cand;
  logic [KW:0]    sh_cross;
  logic [KW:0]    sh_bit;

  assign sh_cross   = {1'b0, bit_i} + 1'b1;
  assign sh_bit     = {bit_i, 1'b0};
  assign cross_term = (WIDTH+1)'(root_i) << sh_cross;
  assign bit_term   = (WIDTH+1)'(1) << sh_bit;
  assign cand       = {1'b0, sq_i} + cross_term + bit_term;

  // overflow counts as larger than any operand
  assign ovf_o       = cand[WIDTH];
  assign keep_o      = !ovf_o && (cand[WIDTH-1:0] <= op_i);
  assign sq_next_o   = cand[WIDTH-1:0];
  assign root_next_o = root_i | (HALF'(1) << bit_i);
endmodule

// File: rtl/isqrt_seq.sv
module isqrt_seq
  import isqrt_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [WIDTH-1:0]     operand_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [WIDTH/2-1:0]   root_o,
  output logic [WIDTH/2:0]     rem_o
);
  localparam int unsigned HALF = WIDTH / 2;
  localparam int unsigned KW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int unsigned RW   = HALF + 1;

  isqrt_state_e      state_q;
  logic [WIDTH-1:0]  op_q;
  logic [WIDTH-1:0]  sq_q;
  logic [HALF-1:0]   root_q;
  logic [KW-1:0]     k_q;

  logic              lead_zero;
  logic [KW-1:0]     lead_top;
  logic              step_keep;
  logic              step_ovf;
  logic [WIDTH-1:0]  step_sq;
  logic [HALF-1:0]   step_root;

  isqrt_lead #(.WIDTH(WIDTH)) u_lead (
    .op_i       (operand_i),
    .zero_o     (lead_zero),
    .top_pair_o (lead_top)
  );

  isqrt_step #(.WIDTH(WIDTH)) u_step (
    .op_i        (op_q),
    .sq_i        (sq_q),
    .root_i      (root_q),
    .bit_i       (k_q),
    .keep_o      (step_keep),
    .ovf_o       (step_ovf),
    .sq_next_o   (step_sq),
    .root_next_o (step_root)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      sq_q    <= '0;
      root_q  <= '0;
      k_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            op_q    <= operand_i;
            sq_q    <= '0;
            root_q  <= '0;
            k_q     <= lead_top;
            state_q <= lead_zero ? ST_DONE : ST_RUN;
          end
        end
        ST_RUN: begin
          if (step_keep) begin
            sq_q   <= step_sq;
            root_q <= step_root;
          end
          if (k_q == '0) state_q <= ST_DONE;
          else           k_q     <= k_q - 1'b1;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_DONE);
  assign root_o = root_q;
  assign rem_o  = RW'(op_q - sq_q);

  // checking aids, full width products
  logic [2*WIDTH-1:0] chk_sq;
  logic [2*WIDTH-1:0] chk_next;
  logic [2*WIDTH-1:0] chk_op;
  assign chk_sq   = (2*WIDTH)'(root_o) * (2*WIDTH)'(root_o);
  assign chk_next = chk_sq + ((2*WIDTH)'(root_o) << 1) + 1'b1;
  assign chk_op   = (2*WIDTH)'(op_q);

  AST_ROOT_BRACKET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (chk_sq <= chk_op) && (chk_op < chk_next)); // R1
  AST_SQ_BELOW_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |-> (sq_q <= op_q)); // R1
  AST_REM_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rem_o == RW'(chk_op - chk_sq))); // R2
  AST_ZERO_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && (operand_i == '0)) |=> (done_o && (root_o == '0) && (rem_o == '0))); // R4
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
  AST_BUSY_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o); // R5
  AST_OP_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(op_q)); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(root_o) && $stable(rem_o))); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |-> !step_ovf); // R9
endmodule

// File: tb/tb_isqrt_seq.sv
`timescale 1ns/1ps
module tb_isqrt_seq;
  localparam int W    = 32;
  localparam int HALF = W / 2;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            start_i = 1'b0;
  logic [W-1:0]    operand_i = '0;
  logic            busy_o;
  logic            done_o;
  logic [HALF-1:0] root_o;
  logic [HALF:0]   rem_o;

  isqrt_seq #(.WIDTH(W)) dut (
    .clk_i, .rst_ni, .start_i, .operand_i, .busy_o, .done_o, .root_o, .rem_o
  );

  always #5 clk_i = ~clk_i;

  typedef struct {
    longint op;
    longint root;
    longint rem;
    int     acc;
    int     lat;
  } item_t;

  item_t  sb_q[$];
  int     cyc = 0;
  int     errs = 0;
  int     checks = 0;
  int     done_seen = 0;
  longint last_root = 0;
  longint last_rem = 0;
  bit     reported = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint ref_root(longint v);
    longint r;
    r = longint'($sqrt(real'(v)));
    while (r * r > v) r--;
    while ((r + 1) * (r + 1) <= v) r++;
    return r;
  endfunction

  function automatic int ref_lat(longint v);
    int p;
    if (v == 0) return 0;
    p = 0;
    for (int i = 0; i < W; i++) if (v[i]) p = i;
    return p / 2 + 1;
  endfunction

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  // driver
  task automatic drive_op(longint v);
    item_t it;
    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
    start_i   = 1'b1;
    operand_i = W'(v);
    it.op   = v;
    it.root = ref_root(v);
    it.rem  = v - it.root * it.root;
    it.acc  = cyc + 1;
    it.lat  = ref_lat(v);
    sb_q.push_back(it);
    @(negedge clk_i);
    start_i   = 1'b0;
    operand_i = '0;
  endtask

  task automatic wait_empty();
    while (sb_q.size() != 0) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  // monitor
  initial begin
    item_t it;
    forever begin
      @(negedge clk_i);
      if (rst_ni && done_o) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R5", "unexpected done", 1, 0);
        end else begin
          it = sb_q.pop_front();
          chk(root_o == HALF'(it.root), "R1", "root", longint'(root_o), it.root);
          chk(rem_o == (HALF+1)'(it.rem), "R2", "remainder", longint'(rem_o), it.rem);
          if (it.op == 0)
            chk(cyc - it.acc == 0, "R4", "zero latency", cyc - it.acc, 0);
          else
            chk(cyc - it.acc == it.lat, "R3", "latency", cyc - it.acc, it.lat);
          chk(busy_o == 1'b1, "R5", "busy with done", longint'(busy_o), 1);
          last_root = it.root;
          last_rem  = it.rem;
          done_seen++;
          @(negedge clk_i);
          chk(done_o == 1'b0, "R5", "done width", longint'(done_o), 0);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(150000 * 10);
    chk(1'b0, "WDOG", "watchdog expired", cyc, 0);
    report();
  end

  initial begin
    // R8 reset state
    repeat (3) @(negedge clk_i);
    chk(busy_o == 0, "R8", "busy in reset", longint'(busy_o), 0);
    chk(done_o == 0, "R8", "done in reset", longint'(done_o), 0);
    chk(root_o == 0, "R8", "root in reset", longint'(root_o), 0);
    chk(rem_o == 0, "R8", "rem in reset", longint'(rem_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R4 zero and tiny operands
    drive_op(0);
    drive_op(1);
    drive_op(2);
    drive_op(3);
    drive_op(4);
    // R9 all ones
    drive_op(longint'({W{1'b1}}));
    wait_empty();
    chk(root_o == {HALF{1'b1}}, "R9", "all-ones root", longint'(root_o), (64'd1 << HALF) - 1);
    chk(rem_o == (HALF+1)'((64'd1 << (HALF+1)) - 2), "R9", "all-ones rem",
        longint'(rem_o), (64'd1 << (HALF+1)) - 2);

    // R3 powers of two, every leading position
    for (int i = 0; i < W; i++) drive_op(64'd1 << i);

    // perfect squares and their neighbours below
    for (int i = 1; i < 12; i++) begin
      longint r;
      r = (64'd1 << HALF) - 64'(i * 977);
      drive_op(r * r);
      drive_op(r * r - 1);
    end
    drive_op(144);
    drive_op(143);

    // R6 start while busy must be ignored
    drive_op(longint'(32'hC000_0001));
    @(negedge clk_i);
    start_i   = 1'b1;
    operand_i = W'(5);
    @(negedge clk_i);
    start_i   = 1'b0;
    operand_i = '0;
    wait_empty();
    chk(root_o == HALF'(ref_root(longint'(32'hC000_0001))), "R6", "root after ignored start",
        longint'(root_o), ref_root(longint'(32'hC000_0001)));

    // R7 results held while idle
    drive_op(1000003);
    wait_empty();
    operand_i = W'(77);
    repeat (6) @(negedge clk_i);
    chk(root_o == HALF'(last_root), "R7", "root held", longint'(root_o), last_root);
    chk(rem_o == (HALF+1)'(last_rem), "R7", "rem held", longint'(rem_o), last_rem);
    operand_i = '0;

    // random operands
    for (int i = 0; i < 60; i++) drive_op(longint'($urandom()));
    for (int i = 0; i < 20; i++) drive_op(longint'($urandom() >> ($urandom() % W)));
    wait_empty();
    chk(sb_q.size() == 0, "R5", "all results returned", sb_q.size(), 0);
    report();
  end
endmodule